// File: doc/BRIEF.md
# E1 Transmit Input Interface

This block sits between the terminal equipment and the transmit pulse shaper of a 2.048 Mbit/s line interface. It takes bipolar transmit data on a positive line and a negative line, and runs entirely from a fast system clock that oversamples those lines. It decides by itself whether the terminal equipment is supplying a transmit bit clock. When that clock toggles, the data lines are taken as NRZ and sampled on each falling edge of the clock. When the clock is idle, the data lines are taken as RZ pulses, and each rising edge starts a mark.

Every accepted mark becomes a pulse on one of two mark-enable outputs, one for each polarity. The pulse is a fixed number of system-clock cycles wide, which by default is half a bit period. A third output enables the line driver. It is dropped under either of two pin conditions: the transmit clock held low with no activity, or both data lines high at once. Both data lines are high, for example, when they are left floating against their pull-ups. While the driver is disabled, no mark is produced.

All three inputs are asynchronous to the system clock. Each passes through a two-stage synchroniser, followed by one more stage that is used to detect edges. All outputs are registered on the system clock.

Top module: `e1_tx_ingress`

## Requirements
- R1: While reset is asserted, mark_pos, mark_neg and drv_en are all 0.
- R2: Any edge, rising or falling, of the synchronised tx_clk_in selects clocked mode. Clocked mode is left once more than 2*SYS_PER_BIT system cycles (196 by default) pass with no such edge. An RZ pulse that arrives inside that window starts no mark.
- R3: In clocked mode, each falling edge of tx_clk_in samples the data lines. A sample of pos=1, neg=0 starts a positive mark, a sample of pos=0, neg=1 starts a negative mark, and 0/0 starts nothing. The mark output rises on the third system-clock edge after the clock fall reaches the input.
- R4: In clockless mode, a rising edge on tx_pos_in while tx_neg_in is low starts a positive mark. A rising edge on tx_neg_in while tx_pos_in is low starts a negative mark.
- R5: An uninterrupted mark is high for exactly MARK_CYC system cycles (49 by default).
- R6: In clocked mode, a sample with both data lines high starts no mark and drives drv_en to 0. drv_en stays 0 until a later falling-edge sample that does not have both lines high.
- R7: In clockless mode, both data lines high together drive drv_en to 0 and start no mark. drv_en returns to 1 once the lines are no longer both high.
- R8: In clockless mode with tx_clk_in held low, drv_en is 0 and data pulses start no mark.
- R9: mark_pos and mark_neg are never high in the same cycle.
- R10: Whenever drv_en is 0, both mark outputs are 0. A mark in progress is cut short when the driver is shut off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk_in | input | 1 | Transmit bit clock from terminal equipment, asynchronous, idle-high when absent |
| tx_pos_in | input | 1 | Positive-polarity data, asynchronous |
| tx_neg_in | input | 1 | Negative-polarity data, asynchronous |
| mark_pos | output | 1 | Positive mark enable to the pulse shaper |
| mark_neg | output | 1 | Negative mark enable to the pulse shaper |
| drv_en | output | 1 | Line driver enable |

## Verification
Two things can land in the same cycle: a mark start and the shutoff decision. Driving both data lines high together in clockless mode, and sampling both high on a clock fall in clocked mode, makes a start candidate and the shutoff appear in one evaluation. In both cases the expected result is that drv_en drops and no mark is produced. A second collision is the clock-activity window closing while an RZ pulse arrives. Pulses placed just inside and well outside the window after the clock stops must produce no mark and a full-width mark, respectively. A behavioural model that tracks edge times and mark end times with integers judges every cycle.

// File: rtl/e1ti_pkg.sv
`timescale 1ns/100ps
package e1ti_pkg;

    // Pin bundle as seen after synchronisation
    typedef struct packed {
        logic clk;
        logic pos;
        logic neg;
    } tx_pins_t;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } mark_pol_e;

    localparam int PIN_W = $bits(tx_pins_t);

    // Idle level of the pins: clock pulled up, data lines pulled up
    localparam tx_pins_t PINS_IDLE = '{clk: 1'b1, pos: 1'b1, neg: 1'b1};

endpackage

// File: rtl/e1ti_sync.sv
`timescale 1ns/100ps
// Multi-stage synchroniser with one extra stage for edge detection.
module e1ti_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q.pipe[i] <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.pipe[STAGES-1];
    assign prv = st_q.pipe[STAGES];

endmodule

// File: rtl/e1ti_activity.sv
`timescale 1ns/100ps
// Judges whether the transmit bit clock is toggling.
module e1ti_activity #(
    parameter int LIMIT = 196
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_cur,
    input  logic lvl_prv,
    output logic chg_o,
    output logic fall_o,
    output logic active_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] idle;
    } act_st_t;

    act_st_t st_d, st_q;
    logic    chg;

    always_comb begin
        st_d = st_q;
        chg  = lvl_cur ^ lvl_prv;
        if (chg) begin
            st_d.idle = '0;
        end else if (st_q.idle != LIM) begin
            st_d.idle = st_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.idle <= LIM;
        else        st_q      <= st_d;
    end

    assign chg_o    = chg;
    assign fall_o   = lvl_prv & ~lvl_cur;
    assign active_o = chg | (st_q.idle < LIM);

endmodule

// File: rtl/e1ti_mark_gen.sv
`timescale 1ns/100ps
// Fixed-width mark timer with polarity.
module e1ti_mark_gen
    import e1ti_pkg::*;
#(
    parameter int MARK = 49
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start_pos,
    input  logic start_neg,
    output logic mark_pos,
    output logic mark_neg
);
    localparam int MW = $clog2(MARK + 1);

    typedef struct packed {
        logic [MW-1:0] left;
        mark_pol_e     pol;
    } mk_st_t;

    mk_st_t st_d, st_q;
    logic [1:0] outs;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.left = '0;
        end else if (start_pos) begin
            st_d.left = MW'(MARK);
            st_d.pol  = POL_POS;
        end else if (start_neg) begin
            st_d.left = MW'(MARK);
            st_d.pol  = POL_NEG;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.left <= '0;
            st_q.pol  <= POL_POS;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_out
        assign outs[gi] = (st_q.left != '0) && (st_q.pol == mark_pol_e'(gi));
    end

    assign mark_pos = outs[0];
    assign mark_neg = outs[1];

endmodule

// File: rtl/e1_tx_ingress.sv
`timescale 1ns/100ps
// Transmit input interface: mode sensing, sampling, mark timing, shutoff.
module e1_tx_ingress
    import e1ti_pkg::*;
#(
    parameter int SYS_PER_BIT = 98,
    parameter int MARK_CYC    = 49,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_clk_in,
    input  logic tx_pos_in,
    input  logic tx_neg_in,
    output logic mark_pos,
    output logic mark_neg,
    output logic drv_en
);
    localparam int IDLE_LIMIT = 2 * SYS_PER_BIT;

    typedef struct packed {
        logic both_lat;
        logic drv_en;
    } top_st_t;

    top_st_t  st_d, st_q;
    tx_pins_t pins_raw, pins_cur, pins_prv;
    logic     clk_chg, clk_fall, clk_active;
    logic     start_p, start_n, shut;

    assign pins_raw = '{clk: tx_clk_in, pos: tx_pos_in, neg: tx_neg_in};

    e1ti_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .cur   (pins_cur),
        .prv   (pins_prv)
    );

    e1ti_activity #(
        .LIMIT (IDLE_LIMIT)
    ) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_cur  (pins_cur.clk),
        .lvl_prv  (pins_prv.clk),
        .chg_o    (clk_chg),
        .fall_o   (clk_fall),
        .active_o (clk_active)
    );

    always_comb begin
        st_d    = st_q;
        start_p = 1'b0;
        start_n = 1'b0;
        if (clk_active) begin
            // clocked NRZ: sample at the falling edge only
            if (clk_fall) begin
                st_d.both_lat = pins_cur.pos & pins_cur.neg;
                start_p       = pins_cur.pos & ~pins_cur.neg;
                start_n       = pins_cur.neg & ~pins_cur.pos;
            end
            shut = st_d.both_lat;
        end else begin
            // clockless RZ: a rising data edge starts a mark
            st_d.both_lat = 1'b0;
            start_p = pins_cur.pos & ~pins_prv.pos & ~pins_cur.neg;
            start_n = pins_cur.neg & ~pins_prv.neg & ~pins_cur.pos;
            shut    = ~pins_cur.clk | (pins_cur.pos & pins_cur.neg);
        end
        st_d.drv_en = ~shut;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.both_lat <= 1'b0;
            st_q.drv_en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    e1ti_mark_gen #(
        .MARK (MARK_CYC)
    ) u_mark (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (shut),
        .start_pos (start_p),
        .start_neg (start_n),
        .mark_pos  (mark_pos),
        .mark_neg  (mark_neg)
    );

    assign drv_en = st_q.drv_en;

endmodule

// File: rtl/e1ti_checker.sv
`timescale 1ns/100ps
module e1ti_checker #(
    parameter int SYS_PER_BIT = 98,
    parameter int MARK_CYC    = 49
) (
    input logic clk,
    input logic rst_n,
    input logic tx_clk_in,
    input logic tx_pos_in,
    input logic tx_neg_in,
    input logic mark_pos,
    input logic mark_neg,
    input logic drv_en
);
    localparam int LIMIT = 2 * SYS_PER_BIT;
    localparam int SAT   = LIMIT + 8;
    localparam int CW    = $clog2(SAT + 1);
    localparam logic [CW-1:0] SATV  = CW'(SAT);
    localparam logic [CW-1:0] HOLDV = CW'(LIMIT + 6);
    localparam logic [CW-1:0] MARKV = CW'(MARK_CYC);

    logic [CW-1:0] both_run, clklo_run, pos_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            both_run  <= '0;
            clklo_run <= '0;
            pos_run   <= '0;
        end else begin
            if (tx_pos_in && tx_neg_in && tx_clk_in)
                both_run <= (both_run == SATV) ? both_run : both_run + 1'b1;
            else
                both_run <= '0;
            if (!tx_clk_in)
                clklo_run <= (clklo_run == SATV) ? clklo_run : clklo_run + 1'b1;
            else
                clklo_run <= '0;
            if (mark_pos)
                pos_run <= (pos_run == SATV) ? pos_run : pos_run + 1'b1;
            else
                pos_run <= '0;
        end
    end

    // R1: quiet outputs while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!mark_pos && !mark_neg && !drv_en)
                else $error("R1 outputs active in reset");
        end
    end

    a_r9_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_pos && mark_neg));

    a_r10_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> (!mark_pos && !mark_neg));

    a_r7_both_high_shutoff: assert property (@(posedge clk) disable iff (!rst_n)
        (both_run >= HOLDV) |-> !drv_en);

    a_r8_clock_low_shutoff: assert property (@(posedge clk) disable iff (!rst_n)
        (clklo_run >= HOLDV) |-> !drv_en);

    a_r5_mark_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mark_pos) && drv_en && !mark_neg) |-> (pos_run >= MARKV));

endmodule

bind e1_tx_ingress e1ti_checker #(
    .SYS_PER_BIT (SYS_PER_BIT),
    .MARK_CYC    (MARK_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_clk_in (tx_clk_in),
    .tx_pos_in (tx_pos_in),
    .tx_neg_in (tx_neg_in),
    .mark_pos  (mark_pos),
    .mark_neg  (mark_neg),
    .drv_en    (drv_en)
);

// File: tb/sim_e1_tx_ingress.sv
`timescale 1ns/100ps
module sim_e1_tx_ingress;
    localparam int SPB   = 98;
    localparam int MARK  = 49;
    localparam int LIMIT = 2 * SPB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_clk_in = 1'b1, tx_pos_in = 1'b1, tx_neg_in = 1'b1;
    logic mark_pos, mark_neg, drv_en;

    int checks = 0, errors = 0;
    bit done = 0, cmp_on = 0;
    string cur_req = "R1";
    int pos_rises = 0, neg_rises = 0;
    logic mp_prev = 0, mn_prev = 0;

    always #2.5 clk = ~clk;

    e1_tx_ingress #(.SYS_PER_BIT(SPB), .MARK_CYC(MARK)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_clk_in(tx_clk_in), .tx_pos_in(tx_pos_in),
        .tx_neg_in(tx_neg_in), .mark_pos(mark_pos), .mark_neg(mark_neg), .drv_en(drv_en));

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0] hq[$];          // raw pin history {clk,pos,neg}, newest last
    int  cyc, last_edge, left;
    bit  pol_neg, both_lat, drv_m;

    always @(posedge clk) begin
        logic [2:0] s, p;
        bit act, sp, sn, off;
        if (!rst_n) begin
            hq = '{3'b111, 3'b111, 3'b111};
            cyc = 0; last_edge = -1000000; left = 0; pol_neg = 0;
            both_lat = 0; drv_m = 0;
        end else begin
            cyc++;
            p = hq[0];
            s = hq[1];
            void'(hq.pop_front());
            hq.push_back({tx_clk_in, tx_pos_in, tx_neg_in});
            if (s[2] != p[2]) last_edge = cyc;
            act = (cyc - last_edge) <= LIMIT;
            sp = 0; sn = 0;
            if (act) begin
                if (p[2] && !s[2]) begin
                    both_lat = s[1] && s[0];
                    sp = s[1] && !s[0];
                    sn = s[0] && !s[1];
                end
                off = both_lat;
            end else begin
                both_lat = 0;
                sp  = s[1] && !p[1] && !s[0];
                sn  = s[0] && !p[0] && !s[1];
                off = !s[2] || (s[1] && s[0]);
            end
            drv_m = !off;
            if (off)      left = 0;
            else if (sp)  begin left = MARK; pol_neg = 0; end
            else if (sn)  begin left = MARK; pol_neg = 1; end
            else if (left > 0) left--;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit ep, en;
        if (rst_n && cmp_on && !done) begin
            ep = (left > 0) && !pol_neg;
            en = (left > 0) && pol_neg;
            chk(mark_pos === ep, cur_req, "mark_pos vs model", int'(mark_pos), int'(ep));
            chk(mark_neg === en, cur_req, "mark_neg vs model", int'(mark_neg), int'(en));
            chk(drv_en === drv_m, cur_req, "drv_en vs model", int'(drv_en), int'(drv_m));
            chk(!(mark_pos && mark_neg), "R9", "both marks high", 1, 0);
            chk(drv_en || (!mark_pos && !mark_neg), "R10", "mark while driver off",
                int'(mark_pos | mark_neg), 0);
        end
        if (mark_pos && !mp_prev) pos_rises++;
        if (mark_neg && !mn_prev) neg_rises++;
        mp_prev = mark_pos;
        mn_prev = mark_neg;
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one RZ bit in clockless style; counts mark and driver-off cycles
    task automatic rz_bit(input bit p, input bit n, output int cp, output int cn, output int clow);
        cp = 0; cn = 0; clow = 0;
        @(negedge clk);
        tx_pos_in = p; tx_neg_in = n;
        for (int i = 0; i < SPB; i++) begin
            @(negedge clk);
            if (i == 44) begin tx_pos_in = 0; tx_neg_in = 0; end
            if (mark_pos) cp++;
            if (mark_neg) cn++;
            if (!drv_en)  clow++;
        end
    endtask

    // clocked NRZ symbols: 0 none, 1 positive, 2 negative, 3 both high
    task automatic run_clocked(input int syms[8], input int n, input bit end_high);
        @(negedge clk);
        #0.3;
        for (int i = 0; i < n; i++) begin
            tx_clk_in = 1'b1;
            tx_pos_in = (syms[i] == 1) || (syms[i] == 3);
            tx_neg_in = (syms[i] == 2) || (syms[i] == 3);
            #244;
            tx_clk_in = 1'b0;
            #244;
        end
        if (end_high) begin
            tx_clk_in = 1'b1; tx_pos_in = 1'b0; tx_neg_in = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        #600000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cp, cn, cl, pr0, nr0;
        // R1: outputs quiet under reset
        idle(4);
        chk(!mark_pos && !mark_neg && !drv_en, "R1", "outputs during reset",
            int'({mark_pos, mark_neg, drv_en}), 0);
        @(negedge clk); rst_n = 1'b1;
        cmp_on = 1;

        // R7: floating data lines (both high) keep the driver off
        cur_req = "R7";
        idle(20);
        chk(drv_en == 0, "R7", "drv_en with floating inputs", int'(drv_en), 0);
        tx_pos_in = 0; tx_neg_in = 0;
        idle(10);
        chk(drv_en == 1, "R7", "drv_en after lines released", int'(drv_en), 1);

        // R4 / R5: clockless marks
        cur_req = "R4";
        rz_bit(1, 0, cp, cn, cl);
        chk(cp == MARK, "R5", "clockless positive mark width", cp, MARK);
        chk(cn == 0, "R4", "no negative mark for positive pulse", cn, 0);
        rz_bit(0, 1, cp, cn, cl);
        chk(cn == MARK, "R4", "clockless negative mark width", cn, MARK);

        // R7: both lines rise together in clockless mode
        cur_req = "R7";
        rz_bit(1, 1, cp, cn, cl);
        chk(cp + cn == 0, "R7", "marks for both-high pulse", cp + cn, 0);
        chk(cl >= 40, "R7", "driver-off cycles for both-high pulse", cl, 45);

        // R3: clocked NRZ sampling
        cur_req = "R3";
        pr0 = pos_rises; nr0 = neg_rises;
        run_clocked('{1, 2, 0, 1, 1, 2, 0, 2}, 8, 1'b1);
        chk(pos_rises - pr0 == 3, "R3", "positive marks in clocked run", pos_rises - pr0, 3);
        chk(neg_rises - nr0 == 3, "R3", "negative marks in clocked run", neg_rises - nr0, 3);

        // R2: RZ pulse inside activity window is ignored, later one is taken
        cur_req = "R2";
        rz_bit(1, 0, cp, cn, cl);
        chk(cp == 0, "R2", "pulse inside clock-activity window", cp, 0);
        idle(LIMIT + 4);
        rz_bit(1, 0, cp, cn, cl);
        chk(cp == MARK, "R2", "pulse after clock declared absent", cp, MARK);

        // R6: both-high sample in clocked mode
        cur_req = "R6";
        pr0 = pos_rises;
        run_clocked('{1, 3, 0, 0, 0, 0, 0, 0}, 2, 1'b1);
        chk(drv_en == 0, "R6", "drv_en after both-high sample", int'(drv_en), 0);
        chk(pos_rises - pr0 == 1, "R6", "marks around both-high sample", pos_rises - pr0, 1);
        nr0 = neg_rises;
        run_clocked('{0, 2, 0, 0, 0, 0, 0, 0}, 2, 1'b1);
        chk(drv_en == 1, "R6", "drv_en after clean sample", int'(drv_en), 1);
        chk(neg_rises - nr0 == 1, "R6", "negative mark after recovery", neg_rises - nr0, 1);
        idle(LIMIT + 4);

        // R8: transmit clock held low
        cur_req = "R8";
        tx_clk_in = 1'b0;
        idle(LIMIT + 10);
        chk(drv_en == 0, "R8", "drv_en with clock held low", int'(drv_en), 0);
        rz_bit(1, 0, cp, cn, cl);
        chk(cp == 0, "R8", "mark with clock held low", cp, 0);
        chk(cl == SPB, "R8", "driver-off cycles with clock low", cl, SPB);
        tx_clk_in = 1'b1;
        idle(LIMIT + 10);
        chk(drv_en == 1, "R8", "drv_en after clock released high", int'(drv_en), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule